// File: doc/BRIEF.md
# DMA Channel Run-State Controller

This block governs whether a single DMA channel is running, draining or stopped. Software writes a small configuration word carrying a run bit, a pause bit and a cacheable-access bit. The block turns those writes, together with a bus-busy flag from the bus master and two hardware stop sources (final linked item finished, channel error), into gates. The gates decide when peripheral requests are accepted into a four-word data FIFO, when the bus side may pull words out, and when the FIFO contents are thrown away.

There are two ways to shut the channel down. Setting the pause bit is the graceful path. New peripheral requests are refused, but the bus side keeps draining the FIFO, and a read-only busy-data status falls to 0 once the FIFO is empty. Clearing the run bit is the abrupt path. The channel waits only for the bus beat in flight to finish, then drops to idle and discards whatever the FIFO still holds. Advancing through linked items never rewrites the configuration word.

Top module: `dma_chan_runctl`

## Requirements
- R1: After reset, rd_enable, rd_halt, rd_active, chan_enabled and hprot_cache are all 0 and no request is acknowledged.
- R2: A configuration write with the run bit set while the channel is idle sets rd_enable on the next cycle. The channel then starts with an empty FIFO, so rd_active is 0.
- R3: A write clearing the run bit while the channel runs holds rd_enable at 1 for as long as bus_busy is 1, with per_ack and drain_valid both 0. In the cycle after bus_busy is seen low, rd_enable and rd_active are both 0, because the FIFO has been emptied.
- R4: A pulse on lli_last_done or chan_err while the channel is enabled clears rd_enable and empties the FIFO by the next cycle.
- R5: While the pause bit is 1, per_req is never acknowledged, yet drain_valid stays 1 while data remains. Clearing the pause bit with the run bit kept at 1 lets requests be acknowledged again.
- R6: rd_active is 1 exactly while the FIFO holds at least one word.
- R7: The FIFO holds 4 words. per_ack is 1 only while fewer than 4 are stored. Each handshake (drain_req with drain_valid) removes one word, and words leave in the order they were accepted.
- R8: chan_enabled equals the value rd_enable had one cycle earlier, whether software or hardware changed it.
- R9: hprot_cache follows the cacheable bit of the last configuration write, including writes made while the channel is idle.
- R10: A write that keeps the run bit at 1 while the channel is enabled does not restart the channel: the FIFO contents and their order are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wr_en | input | 1 | Run bit of the written word |
| cfg_wr_halt | input | 1 | Pause bit of the written word |
| cfg_wr_cache | input | 1 | Cacheable bit of the written word |
| rd_enable | output | 1 | Run bit readback |
| rd_halt | output | 1 | Pause bit readback |
| rd_active | output | 1 | Read-only: FIFO holds data |
| chan_enabled | output | 1 | Run bit delayed by one cycle |
| hprot_cache | output | 1 | Cacheable protection signal to the bus |
| per_req | input | 1 | Peripheral offers one word |
| per_data | input | DW | Offered word |
| per_ack | output | 1 | Word accepted this cycle |
| bus_busy | input | 1 | Bus beat in progress |
| lli_last_done | input | 1 | Final linked item completed |
| chan_err | input | 1 | Channel error |
| drain_req | input | 1 | Bus side takes a word |
| drain_valid | output | 1 | A word may be taken |
| drain_data | output | DW | Word at the FIFO head |

## Verification
A wrong run state shows up at the request and drain gates within the same cycle. A channel stuck running during a stop acknowledges per_req or raises drain_valid while bus_busy is still high. A channel wrongly left paused refuses requests after the pause bit is cleared. Occupancy faults show up in rd_active and in the order of drain_data on the very next handshake. A missed flush shows as rd_active staying 1 one cycle after a stop or a restart. The bench sweeps fill levels against both hardware stop sources and both pause settings, and predicts every word and flag arithmetically.

// File: rtl/dmarc_pkg.sv
`timescale 1ns/1ps
package dmarc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE         = 2'd0,
    ST_RUN          = 2'd1,
    ST_HALT_DRAIN   = 2'd2,
    ST_STOP_PENDING = 2'd3
  } run_state_e;

  // FIFO occupancy after one cycle of push/pop
  function automatic int occ_next(input int occ, input logic push, input logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

  // states in which stored words may leave the FIFO
  function automatic logic may_drain(input run_state_e st);
    return (st == ST_RUN) || (st == ST_HALT_DRAIN);
  endfunction
endpackage

// File: rtl/dmarc_fifo.sv
`timescale 1ns/1ps
module dmarc_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          empty
);
  import dmarc_pkg::*;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= adv(wr_ptr);
      if (pop)  rd_ptr <= adv(rd_ptr);
      occ <= CW'(occ_next(int'(occ), push, pop));
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !flush && wr_ptr == PW'(g)) mem[g] <= push_data;
    end
  end

  assign pop_data = mem[rd_ptr];
  assign full     = (occ == CW'(DEPTH));
  assign empty    = (occ == '0);
endmodule

// File: rtl/dmarc_cfg.sv
`timescale 1ns/1ps
module dmarc_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic wr_halt,
  input  logic wr_cache,
  input  logic start_evt,
  input  logic clr_evt,
  output logic en_q,
  output logic halt_q,
  output logic cache_q,
  output logic en_mirror_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      halt_q      <= 1'b0;
      cache_q     <= 1'b0;
      en_mirror_q <= 1'b0;
    end else begin
      en_mirror_q <= en_q;
      if (clr_evt)        en_q <= 1'b0;
      else if (start_evt) en_q <= 1'b1;
      if (cfg_wr) begin
        halt_q  <= wr_halt;
        cache_q <= wr_cache;
      end
    end
  end
endmodule

// File: rtl/dmarc_fsm.sv
`timescale 1ns/1ps
module dmarc_fsm
  import dmarc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       wr_en,
  input  logic       wr_halt,
  input  logic       halt_q,
  input  logic       bus_busy,
  input  logic       hw_stop,
  output run_state_e state,
  output logic       start_evt,
  output logic       stop_done_evt,
  output logic       hw_stop_evt
);
  run_state_e nxt;
  logic eff_halt;

  assign eff_halt = cfg_wr ? wr_halt : halt_q;

  always_comb begin
    nxt           = state;
    start_evt     = 1'b0;
    stop_done_evt = 1'b0;
    hw_stop_evt   = hw_stop && (state != ST_IDLE);
    if (hw_stop_evt) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cfg_wr && wr_en) begin
            start_evt = 1'b1;
            nxt       = wr_halt ? ST_HALT_DRAIN : ST_RUN;
          end
        end
        ST_RUN, ST_HALT_DRAIN: begin
          if (cfg_wr && !wr_en) nxt = ST_STOP_PENDING;
          else                  nxt = eff_halt ? ST_HALT_DRAIN : ST_RUN;
        end
        ST_STOP_PENDING: begin
          if (!bus_busy) begin
            stop_done_evt = 1'b1;
            nxt           = ST_IDLE;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/dma_chan_runctl.sv
`timescale 1ns/1ps
module dma_chan_runctl #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_wr_en,
  input  logic          cfg_wr_halt,
  input  logic          cfg_wr_cache,
  output logic          rd_enable,
  output logic          rd_halt,
  output logic          rd_active,
  output logic          chan_enabled,
  output logic          hprot_cache,
  input  logic          per_req,
  input  logic [DW-1:0] per_data,
  output logic          per_ack,
  input  logic          bus_busy,
  input  logic          lli_last_done,
  input  logic          chan_err,
  input  logic          drain_req,
  output logic          drain_valid,
  output logic [DW-1:0] drain_data
);
  import dmarc_pkg::*;

  run_state_e    state;
  logic          start_evt, stop_done_evt, hw_stop_evt, hw_stop;
  logic          flush, push, pop, full, empty;
  logic          accept_ok;
  logic [CW-1:0] occ;

  assign hw_stop = lli_last_done | chan_err;

  dmarc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .wr_en(cfg_wr_en),
    .wr_halt(cfg_wr_halt), .halt_q(rd_halt), .bus_busy(bus_busy),
    .hw_stop(hw_stop), .state(state), .start_evt(start_evt),
    .stop_done_evt(stop_done_evt), .hw_stop_evt(hw_stop_evt)
  );

  dmarc_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .wr_halt(cfg_wr_halt),
    .wr_cache(cfg_wr_cache), .start_evt(start_evt),
    .clr_evt(stop_done_evt | hw_stop_evt), .en_q(rd_enable),
    .halt_q(rd_halt), .cache_q(hprot_cache), .en_mirror_q(chan_enabled)
  );

  assign accept_ok   = (state == ST_RUN) && !full && !hw_stop;
  assign per_ack     = per_req && accept_ok;
  assign drain_valid = may_drain(state) && !empty && !hw_stop;
  assign push        = per_ack;
  assign pop         = drain_req && drain_valid;
  assign flush       = start_evt | stop_done_evt | hw_stop_evt;
  assign rd_active   = !empty;

  dmarc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push),
    .push_data(per_data), .pop(pop), .pop_data(drain_data),
    .occ(occ), .full(full), .empty(empty)
  );
endmodule

// File: rtl/dmarc_chk.sv
`timescale 1ns/1ps
module dmarc_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    state,
  input logic          per_ack,
  input logic          drain_valid,
  input logic          rd_enable,
  input logic          chan_enabled,
  input logic          bus_busy,
  input logic          hw_stop,
  input logic [CW-1:0] occ
);
  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_HALT = 2'd2;
  localparam logic [1:0] S_STOP = 2'd3;

  AST_ACK_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> (occ < CW'(DEPTH)));  // R7
  AST_HALT_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HALT) |-> !per_ack);  // R5
  AST_STOP_WAITS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP && bus_busy && !hw_stop) |=> rd_enable);  // R3
  AST_STOP_GATES_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP) |-> (!per_ack && !drain_valid));  // R3
  AST_STOP_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP && !bus_busy) |=> (!rd_enable && occ == '0));  // R3
  AST_HW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_stop && state != S_IDLE) |=> (!rd_enable && occ == '0));  // R4
  AST_MIRROR_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    chan_enabled == $past(rd_enable));  // R8
  AST_START_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_enable) |-> (occ == '0));  // R2
endmodule

bind dma_chan_runctl dmarc_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .per_ack(per_ack),
  .drain_valid(drain_valid), .rd_enable(rd_enable),
  .chan_enabled(chan_enabled), .bus_busy(bus_busy), .hw_stop(hw_stop),
  .occ(occ)
);

// File: tb/sim_dma_chan_runctl.sv
`timescale 1ns/1ps
module sim_dma_chan_runctl;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_wr_en = 1'b0, cfg_wr_halt = 1'b0, cfg_wr_cache = 1'b0;
  logic rd_enable, rd_halt, rd_active, chan_enabled, hprot_cache;
  logic per_req = 1'b0;
  logic [DW-1:0] per_data = '0;
  logic per_ack;
  logic bus_busy = 1'b0, lli_last_done = 1'b0, chan_err = 1'b0, drain_req = 1'b0;
  logic drain_valid;
  logic [DW-1:0] drain_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_chan_runctl #(.DW(DW), .DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic en, input logic halt, input logic cache);
    cfg_wr = 1'b1; cfg_wr_en = en; cfg_wr_halt = halt; cfg_wr_cache = cache;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic push_words(input int n, input int base, input string req);
    for (int i = 0; i < n; i++) begin
      per_req = 1'b1; per_data = DW'(base + i);
      #1 chk(req, "per_ack while filling", per_ack, 1);
      tick();
    end
    per_req = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R1", "rd_enable", rd_enable, 0);
    chk("R1", "rd_halt", rd_halt, 0);
    chk("R1", "rd_active", rd_active, 0);
    chk("R1", "chan_enabled", chan_enabled, 0);
    chk("R1", "hprot_cache", hprot_cache, 0);
    rst_n = 1'b1;
    tick();
    per_req = 1'b1;
    #1 chk("R1", "per_ack idle", per_ack, 0);
    per_req = 1'b0;

    // start
    wr(1, 0, 1);
    chk("R2", "rd_enable after start", rd_enable, 1);
    chk("R2", "rd_active after start", rd_active, 0);
    chk("R9", "hprot_cache", hprot_cache, 1);
    chk("R8", "chan_enabled lags", chan_enabled, 0);
    tick();
    chk("R8", "chan_enabled follows", chan_enabled, 1);

    // fill beyond depth: ack only while fewer than DEPTH stored
    for (int i = 0; i < DEPTH + 2; i++) begin
      per_req = 1'b1; per_data = DW'(100 + i);
      #1 chk("R7", "per_ack vs fill", per_ack, (i < DEPTH) ? 1 : 0);
      tick();
      chk("R6", "rd_active after push", rd_active, 1);
    end
    per_req = 1'b0;

    // drain in order
    drain_req = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      #1 chk("R7", "drain_valid", drain_valid, 1);
      chk("R7", "drain order", drain_data, 100 + i);
      tick();
      chk("R6", "rd_active after pop", rd_active, (i < DEPTH - 1) ? 1 : 0);
    end
    drain_req = 1'b0;

    // graceful pause, sweep of fill levels
    for (int n = 1; n <= DEPTH; n++) begin
      push_words(n, 200 + 10 * n, "R5");
      wr(1, 1, 1);
      chk("R10", "data kept on rewrite", rd_active, 1);
      chk("R5", "rd_halt", rd_halt, 1);
      per_req = 1'b1;
      #1 chk("R5", "per_ack while paused", per_ack, 0);
      tick();
      per_req = 1'b0;
      drain_req = 1'b1;
      for (int i = 0; i < n; i++) begin
        #1 chk("R5", "drain_valid while paused", drain_valid, 1);
        chk("R10", "order kept", drain_data, 200 + 10 * n + i);
        tick();
      end
      drain_req = 1'b0;
      #1 chk("R6", "rd_active drained", rd_active, 0);
      wr(1, 0, 1);
      per_req = 1'b1; per_data = 32'h55;
      #1 chk("R5", "per_ack resumes", per_ack, 1);
      per_req = 1'b0;
    end

    // abrupt stop with a bus beat in flight
    push_words(2, 300, "R3");
    bus_busy = 1'b1;
    wr(0, 0, 1);
    per_req = 1'b1; drain_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1 chk("R3", "per_ack during stop", per_ack, 0);
      chk("R3", "drain_valid during stop", drain_valid, 0);
      chk("R3", "rd_enable held", rd_enable, 1);
      chk("R3", "rd_active held", rd_active, 1);
      tick();
    end
    per_req = 1'b0; drain_req = 1'b0; bus_busy = 1'b0;
    tick();
    chk("R3", "rd_enable cleared", rd_enable, 0);
    chk("R3", "fifo discarded", rd_active, 0);
    chk("R8", "chan_enabled lags clear", chan_enabled, 1);
    tick();
    chk("R8", "chan_enabled cleared", chan_enabled, 0);

    // hardware stop sweep: source x fill level
    for (int src = 0; src < 2; src++) begin
      for (int n = 1; n <= DEPTH; n++) begin
        wr(1, 0, 0);
        chk("R2", "restart empty", rd_active, 0);
        chk("R9", "hprot_cache cleared", hprot_cache, 0);
        push_words(n, 400, "R4");
        chk("R6", "rd_active filled", rd_active, 1);
        if (src == 0) chan_err = 1'b1; else lli_last_done = 1'b1;
        tick();
        chan_err = 1'b0; lli_last_done = 1'b0;
        chk("R4", "rd_enable hw cleared", rd_enable, 0);
        chk("R4", "fifo emptied", rd_active, 0);
        tick();
        chk("R8", "chan_enabled after hw", chan_enabled, 0);
      end
    end

    // start directly into pause
    wr(1, 1, 0);
    chk("R2", "rd_enable paused start", rd_enable, 1);
    per_req = 1'b1;
    #1 chk("R5", "per_ack paused start", per_ack, 0);
    per_req = 1'b0;
    wr(0, 1, 0);
    tick();
    chk("R3", "stop without bus beat", rd_enable, 0);

    // idle write changes only the protection bit
    wr(0, 0, 1);
    chk("R9", "hprot_cache idle write", hprot_cache, 1);
    chk("R9", "rd_enable stays 0", rd_enable, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule